// File: doc/BRIEF.md
# Display Pixel Output Formatter

This block sits at the end of a display pipeline. It receives one pixel per clock as three 12-bit channels and shapes it for a parallel display bus. Channel 0 carries red or Cr, channel 1 carries green or Y, and channel 2 carries blue or Cb. A pixel passes through three registered stages. The first stage applies an optional red/blue exchange and then clamps luma and chroma to programmable windows. The second stage either permutes the three channels into one of six orders or packs YCbCr 4:2:2, with luma plus alternating chroma on two lanes. The third stage truncates or widens every lane to the selected bus depth.

The qualifiers valid, data-enable, horizontal sync and vertical sync are delayed to stay aligned with the data. All configuration inputs are quasi-static. Each stage samples them when the pixel passes through it, so the system changes them only while no valid pixel is in flight. Typical clamp windows are 0x010 to 0xFE0 for both luma and chroma.

Top module: `pix_out_fmt`

## Requirements
- R1: When `rb_swap_i` is 1, channels 0 and 2 are exchanged before clamping, reordering and packing. When it is 0, they are left in place.
- R2: When `clamp_en_i` is 1, channel 1 is limited to [`y_lo_i`, `y_hi_i`] and channels 0 and 2 to [`c_lo_i`, `c_hi_i`]. A value below the lower limit becomes the lower limit; otherwise a value above the upper limit becomes the upper limit. When `clamp_en_i` is 0, values pass unchanged.
- R3: When `yc422_i` is 0, `order_i` places the channels R=ch0, G=ch1, B=ch2 on lanes 0, 1 and 2. The codes are 0 RGB, 1 GBR, 2 BRG, 3 RBG, 4 GRB and 5 BGR, where the first letter goes to lane 0. Codes 6 and 7 behave as RGB.
- R4: When `yc422_i` is 1, lane 2 is zero and lanes 0 and 1 carry Y (ch1) and one chroma sample. The chroma is Cb (ch2) when the line phase is even and Cr (ch0) when it is odd.
- R5: The line phase starts at 0 after reset. Each valid pixel with DE high toggles it, and each valid pixel with DE low clears it, so the first active pixel of a line always carries Cb. Cycles with valid low leave the phase unchanged.
- R6: In 4:2:2 mode, `ycmap_i` selects which lane gets the chroma sample:
  - Code 3 puts chroma on lane 0.
  - Codes 0, 4, 5, 6 and 7 put luma on lane 0.
  - Code 1 puts chroma on lane 0 at even phase and on lane 1 at odd phase.
  - Code 2 does the opposite of code 1.
  - In every case, the other of lanes 0 and 1 gets the remaining sample.
- R7: `depth_i` codes 0, 1, 2 and 3 select 8, 10, 12 and 16 output bits, right-aligned with zero upper bits. Reducing depth keeps the most significant input bits. At 16 bits, the output is the 12-bit value followed by its top 4 bits.
- R8: `depth_i` codes 4 to 7 give the 8-bit result.
- R9: Valid, DE, hsync, vsync and data appear at the outputs exactly 3 clocks after they enter.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input pixel valid |
| de_i | input | 1 | Input data enable |
| hs_i | input | 1 | Input horizontal sync |
| vs_i | input | 1 | Input vertical sync |
| ch0_i | input | IN_W | Red / Cr sample |
| ch1_i | input | IN_W | Green / Y sample |
| ch2_i | input | IN_W | Blue / Cb sample |
| rb_swap_i | input | 1 | Exchange channels 0 and 2 |
| clamp_en_i | input | 1 | Enable range clamping |
| y_lo_i | input | IN_W | Luma lower limit |
| y_hi_i | input | IN_W | Luma upper limit |
| c_lo_i | input | IN_W | Chroma lower limit |
| c_hi_i | input | IN_W | Chroma upper limit |
| order_i | input | 3 | Channel permutation code |
| yc422_i | input | 1 | Enable 4:2:2 packing |
| ycmap_i | input | 3 | Luma/chroma lane layout code |
| depth_i | input | 3 | Output depth code |
| valid_o | output | 1 | Output pixel valid |
| de_o | output | 1 | Output data enable |
| hs_o | output | 1 | Output horizontal sync |
| vs_o | output | 1 | Output vertical sync |
| lane0_o | output | OUT_W | Output lane 0 |
| lane1_o | output | OUT_W | Output lane 1 |
| lane2_o | output | OUT_W | Output lane 2 |

## Verification
The bench sweeps every combination of swap, clamp enable, all eight order codes, all eight layout codes with packing on, and all eight depth codes. The pixel data mixes values below, inside and above windows that differ for luma and chroma, so applying the luma limits to a chroma channel, or testing the bounds in the wrong order, shows up as wrong lane values. Each line contains a valid-low gap and a short DE-low gap. A phase that advances on invalid cycles, or that fails to restart at a new line, gives Cr where Cb belongs and the wrong CYCY/YCYC lane order. Any depth code outside 0 to 3 is checked against the 8-bit result, and 16-bit widening is checked for replicating the top bits rather than padding with zeros.

// File: rtl/pof_pkg.sv
package pof_pkg;
  localparam int NCH = 3;

  localparam logic [2:0] ORD_RGB = 3'd0;
  localparam logic [2:0] ORD_GBR = 3'd1;
  localparam logic [2:0] ORD_BRG = 3'd2;
  localparam logic [2:0] ORD_RBG = 3'd3;
  localparam logic [2:0] ORD_GRB = 3'd4;
  localparam logic [2:0] ORD_BGR = 3'd5;

  localparam logic [2:0] MAP_CYCY = 3'd1;
  localparam logic [2:0] MAP_YCYC = 3'd2;
  localparam logic [2:0] MAP_CY   = 3'd3;

  localparam logic [2:0] DEP_10 = 3'd1;
  localparam logic [2:0] DEP_12 = 3'd2;
  localparam logic [2:0] DEP_16 = 3'd3;

  typedef struct packed {
    logic valid;
    logic de;
    logic hs;
    logic vs;
  } side_t;
endpackage

// File: rtl/pof_swap_clamp.sv
module pof_swap_clamp import pof_pkg::*; #(
  parameter int W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rb_swap_i,
  input  logic                  clamp_en_i,
  input  logic [W-1:0]          y_lo_i,
  input  logic [W-1:0]          y_hi_i,
  input  logic [W-1:0]          c_lo_i,
  input  logic [W-1:0]          c_hi_i,
  input  logic [NCH-1:0][W-1:0] pix_i,
  output logic [NCH-1:0][W-1:0] pix_o
);
  logic [NCH-1:0][W-1:0] sw, cl;

  assign sw = rb_swap_i ? {pix_i[0], pix_i[1], pix_i[2]} : pix_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [W-1:0] lo, hi;
    // channel 1 is luma, outer channels are chroma
    assign lo = (g == 1) ? y_lo_i : c_lo_i;
    assign hi = (g == 1) ? y_hi_i : c_hi_i;
    always_comb begin
      if (clamp_en_i && sw[g] < lo)      cl[g] = lo;
      else if (clamp_en_i && sw[g] > hi) cl[g] = hi;
      else                               cl[g] = sw[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= cl;
  end
endmodule

// File: rtl/pof_pack.sv
module pof_pack import pof_pkg::*; #(
  parameter int W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  de_i,
  input  logic                  yc422_i,
  input  logic [2:0]            ycmap_i,
  input  logic [2:0]            order_i,
  input  logic [NCH-1:0][W-1:0] pix_i,
  output logic [NCH-1:0][W-1:0] lanes_o
);
  logic            phase_q;
  logic            c_first;
  logic [W-1:0]    c_smp, y_smp;
  logic [NCH-1:0][W-1:0] lanes_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= 1'b0;
    else if (valid_i) phase_q <= de_i ? ~phase_q : 1'b0;
  end

  always_comb begin
    c_smp = phase_q ? pix_i[0] : pix_i[2];
    y_smp = pix_i[1];
    case (ycmap_i)
      MAP_CYCY: c_first = ~phase_q;
      MAP_YCYC: c_first = phase_q;
      MAP_CY:   c_first = 1'b1;
      default:  c_first = 1'b0;
    endcase
    if (yc422_i) begin
      lanes_d = {{W{1'b0}}, (c_first ? y_smp : c_smp), (c_first ? c_smp : y_smp)};
    end else begin
      // index 0 is lane 0; pix index 0/1/2 = R/G/B
      case (order_i)
        ORD_GBR: lanes_d = {pix_i[0], pix_i[2], pix_i[1]};
        ORD_BRG: lanes_d = {pix_i[1], pix_i[0], pix_i[2]};
        ORD_RBG: lanes_d = {pix_i[1], pix_i[2], pix_i[0]};
        ORD_GRB: lanes_d = {pix_i[2], pix_i[0], pix_i[1]};
        ORD_BGR: lanes_d = {pix_i[0], pix_i[1], pix_i[2]};
        default: lanes_d = pix_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lanes_o <= '0;
    else         lanes_o <= lanes_d;
  end
endmodule

// File: rtl/pof_depth.sv
module pof_depth import pof_pkg::*; #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [2:0]                depth_i,
  input  logic [NCH-1:0][IN_W-1:0]  pix_i,
  output logic [NCH-1:0][OUT_W-1:0] lanes_o
);
  localparam int EXT_W = OUT_W - IN_W;

  logic [NCH-1:0][OUT_W-1:0] lanes_d;

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    always_comb begin
      case (depth_i)
        DEP_10:  lanes_d[g] = OUT_W'(pix_i[g] >> (IN_W - 10));
        DEP_12:  lanes_d[g] = OUT_W'(pix_i[g] >> (IN_W - 12));
        DEP_16:  lanes_d[g] = {pix_i[g], pix_i[g][IN_W-1 -: EXT_W]};
        default: lanes_d[g] = OUT_W'(pix_i[g] >> (IN_W - 8));
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lanes_o <= '0;
    else         lanes_o <= lanes_d;
  end
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt import pof_pkg::*; #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             de_i,
  input  logic             hs_i,
  input  logic             vs_i,
  input  logic [IN_W-1:0]  ch0_i,
  input  logic [IN_W-1:0]  ch1_i,
  input  logic [IN_W-1:0]  ch2_i,
  input  logic             rb_swap_i,
  input  logic             clamp_en_i,
  input  logic [IN_W-1:0]  y_lo_i,
  input  logic [IN_W-1:0]  y_hi_i,
  input  logic [IN_W-1:0]  c_lo_i,
  input  logic [IN_W-1:0]  c_hi_i,
  input  logic [2:0]       order_i,
  input  logic             yc422_i,
  input  logic [2:0]       ycmap_i,
  input  logic [2:0]       depth_i,
  output logic             valid_o,
  output logic             de_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic [OUT_W-1:0] lane0_o,
  output logic [OUT_W-1:0] lane1_o,
  output logic [OUT_W-1:0] lane2_o
);
  localparam int LAT = 3;

  logic [NCH-1:0][IN_W-1:0]  s1_pix, s2_pix;
  logic [NCH-1:0][OUT_W-1:0] s3_pix;
  side_t                     side_q [LAT];

  pof_swap_clamp #(.W(IN_W)) u_s1 (
    .clk_i, .rst_ni, .rb_swap_i, .clamp_en_i,
    .y_lo_i, .y_hi_i, .c_lo_i, .c_hi_i,
    .pix_i ({ch2_i, ch1_i, ch0_i}),
    .pix_o (s1_pix)
  );

  pof_pack #(.W(IN_W)) u_s2 (
    .clk_i, .rst_ni,
    .valid_i (side_q[0].valid),
    .de_i    (side_q[0].de),
    .yc422_i, .ycmap_i, .order_i,
    .pix_i   (s1_pix),
    .lanes_o (s2_pix)
  );

  pof_depth #(.IN_W(IN_W), .OUT_W(OUT_W)) u_s3 (
    .clk_i, .rst_ni, .depth_i,
    .pix_i   (s2_pix),
    .lanes_o (s3_pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LAT; i++) side_q[i] <= '0;
    end else begin
      side_q[0] <= '{valid: valid_i, de: de_i, hs: hs_i, vs: vs_i};
      for (int i = 1; i < LAT; i++) side_q[i] <= side_q[i-1];
    end
  end

  assign valid_o = side_q[LAT-1].valid;
  assign de_o    = side_q[LAT-1].de;
  assign hs_o    = side_q[LAT-1].hs;
  assign vs_o    = side_q[LAT-1].vs;
  assign lane0_o = s3_pix[0];
  assign lane1_o = s3_pix[1];
  assign lane2_o = s3_pix[2];
endmodule

// File: rtl/pof_checker.sv
module pof_checker #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    de_i,
  input logic                    hs_i,
  input logic                    vs_i,
  input logic                    valid_o,
  input logic                    de_o,
  input logic                    hs_o,
  input logic                    vs_o,
  input logic                    clamp_en_i,
  input logic [IN_W-1:0]         y_lo_i,
  input logic [IN_W-1:0]         y_hi_i,
  input logic [IN_W-1:0]         c_lo_i,
  input logic [IN_W-1:0]         c_hi_i,
  input logic [2:0][IN_W-1:0]    s1_pix,
  input logic                    yc422_i,
  input logic [2:0]              depth_i,
  input logic [OUT_W-1:0]        lane0_o,
  input logic [OUT_W-1:0]        lane1_o,
  input logic [OUT_W-1:0]        lane2_o
);
  logic [1:0] cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc == 2'd3 |-> valid_o == $past(valid_i, 3) && de_o == $past(de_i, 3) &&
                    hs_o == $past(hs_i, 3) && vs_o == $past(vs_i, 3));

  assert_luma_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc != 2'd0 && $past(clamp_en_i) && $past(y_lo_i) <= $past(y_hi_i) |->
      s1_pix[1] >= $past(y_lo_i) && s1_pix[1] <= $past(y_hi_i));

  assert_chroma_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc != 2'd0 && $past(clamp_en_i) && $past(c_lo_i) <= $past(c_hi_i) |->
      s1_pix[0] >= $past(c_lo_i) && s1_pix[0] <= $past(c_hi_i) &&
      s1_pix[2] >= $past(c_lo_i) && s1_pix[2] <= $past(c_hi_i));

  assert_lane2_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc >= 2'd2 && valid_o && $past(yc422_i, 2) |-> lane2_o == '0);

  assert_depth8_upper_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc != 2'd0 && ($past(depth_i) == 3'd0 || $past(depth_i) >= 3'd4) |->
      lane0_o[OUT_W-1:8] == '0 && lane1_o[OUT_W-1:8] == '0 && lane2_o[OUT_W-1:8] == '0);
endmodule

bind pix_out_fmt pof_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk_i, .rst_ni, .valid_i, .de_i, .hs_i, .vs_i,
  .valid_o, .de_o, .hs_o, .vs_o,
  .clamp_en_i, .y_lo_i, .y_hi_i, .c_lo_i, .c_hi_i,
  .s1_pix (s1_pix),
  .yc422_i, .depth_i, .lane0_o, .lane1_o, .lane2_o
);

// File: tb/test_pix_out_fmt.sv
`timescale 1ns/1ps
module test_pix_out_fmt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, de_i = 1'b0, hs_i = 1'b0, vs_i = 1'b0;
  logic [11:0] ch0_i = '0, ch1_i = '0, ch2_i = '0;
  logic        rb_swap_i = 1'b0, clamp_en_i = 1'b0, yc422_i = 1'b0;
  logic [11:0] y_lo_i = 12'h010, y_hi_i = 12'hFE0, c_lo_i = 12'h040, c_hi_i = 12'hF00;
  logic [2:0]  order_i = '0, ycmap_i = '0, depth_i = '0;
  logic        valid_o, de_o, hs_o, vs_o;
  logic [15:0] lane0_o, lane1_o, lane2_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic ph = 1'b0;
  int unsigned seed = 32'h1234_5678;

  typedef struct {
    logic v, de, hs, vs;
    logic [15:0] l0, l1, l2;
    string tag;
  } exp_t;
  exp_t q [3];

  always #2.5 clk_i = ~clk_i;

  pix_out_fmt i_pix_out_fmt (.*);

  function automatic logic [11:0] clampv(logic [11:0] v, logic [11:0] lo, logic [11:0] hi);
    if (!clamp_en_i) return v;
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [15:0] dep(logic [11:0] v);
    case (depth_i)
      3'd1: return {6'd0, v[11:2]};
      3'd2: return {4'd0, v};
      3'd3: return {v, v[11:8]};
      default: return {8'd0, v[11:4]};
    endcase
  endfunction

  function automatic exp_t model(logic v, logic de, logic hs, logic vs,
                                 logic [11:0] a0, logic [11:0] a1, logic [11:0] a2, logic p);
    exp_t e;
    logic [11:0] r, g, b, l0, l1, l2, c;
    logic cf;
    r = clampv(rb_swap_i ? a2 : a0, c_lo_i, c_hi_i);
    g = clampv(a1, y_lo_i, y_hi_i);
    b = clampv(rb_swap_i ? a0 : a2, c_lo_i, c_hi_i);
    if (yc422_i) begin
      c  = p ? r : b;
      cf = (ycmap_i == 3'd3) || (ycmap_i == 3'd1 && !p) || (ycmap_i == 3'd2 && p);
      l0 = cf ? c : g; l1 = cf ? g : c; l2 = '0;
      e.tag = $sformatf("R1 R2 R4 R5 R6 R7 R8 map=%0d ph=%0d dep=%0d", ycmap_i, p, depth_i);
    end else begin
      case (order_i)
        3'd1: begin l0 = g; l1 = b; l2 = r; end
        3'd2: begin l0 = b; l1 = r; l2 = g; end
        3'd3: begin l0 = r; l1 = b; l2 = g; end
        3'd4: begin l0 = g; l1 = r; l2 = b; end
        3'd5: begin l0 = b; l1 = g; l2 = r; end
        default: begin l0 = r; l1 = g; l2 = b; end
      endcase
      e.tag = $sformatf("R1 R2 R3 R7 R8 ord=%0d dep=%0d", order_i, depth_i);
    end
    e.v = v; e.de = de; e.hs = hs; e.vs = vs;
    e.l0 = dep(l0); e.l1 = dep(l1); e.l2 = dep(l2);
    return e;
  endfunction

  task automatic step(logic v, logic de, logic hs, logic vs,
                      logic [11:0] a0, logic [11:0] a1, logic [11:0] a2);
    logic p;
    @(negedge clk_i);
    n_chk++;
    if ({valid_o, de_o, hs_o, vs_o} !== {q[2].v, q[2].de, q[2].hs, q[2].vs}) begin
      n_fail++;
      $display("FAIL R9 sideband got %b exp %b", {valid_o, de_o, hs_o, vs_o},
               {q[2].v, q[2].de, q[2].hs, q[2].vs});
    end
    if (q[2].v) begin
      n_chk++;
      if ({lane0_o, lane1_o, lane2_o} !== {q[2].l0, q[2].l1, q[2].l2}) begin
        n_fail++;
        $display("FAIL %s lanes got %h %h %h exp %h %h %h", q[2].tag,
                 lane0_o, lane1_o, lane2_o, q[2].l0, q[2].l1, q[2].l2);
      end
    end
    p = ph;
    if (v) ph = de ? ~ph : 1'b0;
    q[2] = q[1]; q[1] = q[0];
    q[0] = model(v, de, hs, vs, a0, a1, a2, p);
    valid_i = v; de_i = de; hs_i = hs; vs_i = vs;
    ch0_i = a0; ch1_i = a1; ch2_i = a2;
  endtask

  function automatic logic [11:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[27:16];
  endfunction

  task automatic run_line();
    logic [11:0] a0, a1, a2;
    for (int p = 0; p < 14; p++) begin
      a0 = rnd(); a1 = rnd(); a2 = rnd();
      if (p % 4 == 0) begin a0 = 12'h000; a1 = 12'hFFF; a2 = 12'h020; end
      if (p % 4 == 2) begin a0 = 12'hFF0; a1 = 12'h008; a2 = 12'hF80; end
      step(p != 6, !(p == 9 || p == 10), p[0], p == 2, a0, a1, a2);
    end
    for (int d = 0; d < 3; d++) step(1'b0, 1'b0, 1'b0, 1'b0, rnd(), rnd(), rnd());
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin q[i] = '{default: '0}; q[i].tag = ""; end
    valid_i = 1'b1; de_i = 1'b1; hs_i = 1'b1; vs_i = 1'b1;
    ch0_i = 12'hABC; ch1_i = 12'h123; ch2_i = 12'h456;
    repeat (4) @(negedge clk_i);
    n_chk++;
    if ({valid_o, de_o, hs_o, vs_o, lane0_o, lane1_o, lane2_o} !== '0) begin
      n_fail++;
      $display("FAIL R10 reset outputs got %b/%h/%h/%h exp 0", {valid_o, de_o, hs_o, vs_o},
               lane0_o, lane1_o, lane2_o);
    end
    valid_i = 1'b0; de_i = 1'b0; hs_i = 1'b0; vs_i = 1'b0;
    rst_ni = 1'b1;
    for (int sw = 0; sw < 2; sw++)
      for (int ce = 0; ce < 2; ce++)
        for (int dp = 0; dp < 8; dp++) begin
          for (int od = 0; od < 8; od++) begin
            rb_swap_i = sw[0]; clamp_en_i = ce[0]; depth_i = dp[2:0];
            yc422_i = 1'b0; order_i = od[2:0];
            run_line();
          end
          for (int mp = 0; mp < 8; mp++) begin
            rb_swap_i = sw[0]; clamp_en_i = ce[0]; depth_i = dp[2:0];
            yc422_i = 1'b1; ycmap_i = mp[2:0];
            run_line();
          end
        end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule